// File: doc/BRIEF.md
# Clocked Three-Port Bank Exchanger

This block sits between one host-side data port (A) and two memory-bank ports (B1 and B2). It lets the host interleave traffic across the two banks. Four holding registers carry the traffic: two outbound (A to B1, A to B2) and two inbound (B1 to A, B2 to A). Each holding register has its own active-low load strobe. One host word can therefore be placed in either bank register or in both on the same edge.

The inbound select and the two drive enables are also captured on the rising clock edge. This makes every change of direction and every change of bank a clocked event. All outputs come from registered state only.

Each bidirectional pin is split into a value input, an "externally driven" flag, a value output and a drive-enable output. A wrapper can add the tri-state buffers. Each port's input path has a keeper. When nobody drives the pin, the keeper holds the last level the pin carried. When the block itself drives the pin, the input path sees the block's own output.

Top module: `xchg_bank_exchanger`

## Requirements
- R1: A synchronous active-high reset clears all four holding registers to zero. It releases all three ports (`a_oe`, `b1_oe` and `b2_oe` low) and sets the inbound select to B1. The outputs show this state one rising edge after `rst` is sampled high.
- R2: When `ld_a_b1_n` is 0 at a rising edge, the A-side input level is stored in the A-to-B1 register, and `b1_out` shows it after that edge.
- R3: When `ld_a_b2_n` is 0 at a rising edge, the A-side input level is stored in the A-to-B2 register. If both outbound strobes are 0 on the same edge, both registers take the same word.
- R4: When `ld_b1_a_n` is 0 at an edge, the B1 input path is stored in the B1-to-A register. When `ld_b2_a_n` is 0, the B2 input path is stored in the B2-to-A register.
- R5: A holding register whose strobe is 1 at an edge keeps its previous word, and its output keeps presenting that word.
- R6: `rsel` is sampled at each rising edge. A sampled 1 makes `a_out` present the B1-to-A register after that edge. A sampled 0 makes it present the B2-to-A register.
- R7: `a_oe` equals the inverse of `a_en_n` as sampled at the most recent rising edge (`a_en_n` is active low).
- R8: `b1_oe` and `b2_oe` both equal the inverse of `b_en_n` as sampled at the most recent rising edge. With the B ports released, external B data can be loaded inbound.
- R9: Each port's input path takes its level from three sources, in this order of priority. First, the external value when the pin's drive flag is 1. Otherwise, the block's own output for that port when its drive enable is on. Otherwise, the level held from the previous cycle.
- R10: No output depends combinationally on an input. Changing any input between edges leaves every output unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Level on the A pins from outside |
| a_drv | input | 1 | 1 when an external agent drives the A pins |
| a_out | output | 12 | Word the block presents on A |
| a_oe | output | 1 | Block drives A when 1 |
| b1_in | input | 12 | Level on the B1 pins from outside |
| b1_drv | input | 1 | 1 when an external agent drives B1 |
| b1_out | output | 12 | Word the block presents on B1 |
| b1_oe | output | 1 | Block drives B1 when 1 |
| b2_in | input | 12 | Level on the B2 pins from outside |
| b2_drv | input | 1 | 1 when an external agent drives B2 |
| b2_out | output | 12 | Word the block presents on B2 |
| b2_oe | output | 1 | Block drives B2 when 1 |
| ld_a_b1_n | input | 1 | Load strobe, A-to-B1 register, active low |
| ld_a_b2_n | input | 1 | Load strobe, A-to-B2 register, active low |
| ld_b1_a_n | input | 1 | Load strobe, B1-to-A register, active low |
| ld_b2_a_n | input | 1 | Load strobe, B2-to-A register, active low |
| rsel | input | 1 | Inbound select: 1 picks B1, 0 picks B2 |
| a_en_n | input | 1 | A drive enable, active low |
| b_en_n | input | 1 | Shared B1/B2 drive enable, active low |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it: a stored word, a change of inbound bank, or a change of drive enable. A keeper capture affects a holding register only at a later load edge. The bench changes inputs just after a falling edge and lets one rising edge pass. It then advances its behavioural model by one step and compares all outputs at the next falling edge, so each comparison lands on the cycle where the result is due. For the combinational-path requirement, the bench changes inputs in the middle of a cycle and checks that the outputs are still the values seen before the change.

// File: rtl/xchg_pkg.sv
`timescale 1ns/1ps
package xchg_pkg;
  // holding-register indices
  localparam int P_A_B1   = 0;
  localparam int P_A_B2   = 1;
  localparam int P_B1_A   = 2;
  localparam int P_B2_A   = 3;
  localparam int NUM_PATHS = 4;

  // port indices
  localparam int PORT_A   = 0;
  localparam int PORT_B1  = 1;
  localparam int PORT_B2  = 2;
  localparam int NUM_PORTS = 3;

  typedef struct packed {
    logic sel_b1;  // inbound select: 1 = B1 register
    logic a_off;   // A released
    logic b_off;   // B1/B2 released
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{sel_b1: 1'b1, a_off: 1'b1, b_off: 1'b1};
endpackage

// File: rtl/xchg_keeper.sv
`timescale 1ns/1ps
module xchg_keeper #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_drv,
  input  logic [W-1:0] ext_val,
  input  logic         own_oe,
  input  logic [W-1:0] own_val,
  output logic [W-1:0] seen
);
  logic [W-1:0] hold_q;

  // external driver wins over own drive; otherwise the held level
  always_comb begin
    if (ext_drv)     seen = ext_val;
    else if (own_oe) seen = own_val;
    else             seen = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= seen;
  end

  // R9: with nobody driving the pin, the input path keeps last cycle's level
  p_keep_level_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ext_drv && !own_oe) |-> (seen == $past(seen)));

  // R9: an external driver is always what the input path reports
  p_ext_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ext_drv |-> (seen == ext_val));
endmodule

// File: rtl/xchg_dreg.sv
`timescale 1ns/1ps
module xchg_dreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ld_n) q <= d;
  end

  // R2/R3/R4: a low strobe stores the presented word
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_n)) |-> (q == $past(d)));

  // R5: a high strobe keeps the word
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_n)) |-> $stable(q));
endmodule

// File: rtl/xchg_ctrl.sv
`timescale 1ns/1ps
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rsel,
  input  logic  a_en_n,
  input  logic  b_en_n,
  output ctrl_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RESET;
    else begin
      ctrl_q.sel_b1 <= rsel;
      ctrl_q.a_off  <= a_en_n;
      ctrl_q.b_off  <= b_en_n;
    end
  end

  // R6: select follows its input one edge later
  p_sel_lag_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ctrl_q.sel_b1 == $past(rsel)));

  // R7: A enable follows one edge later
  p_a_en_lag_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ctrl_q.a_off == $past(a_en_n)));

  // R8: shared B enable follows one edge later
  p_b_en_lag_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ctrl_q.b_off == $past(b_en_n)));
endmodule

// File: rtl/xchg_bank_exchanger.sv
`timescale 1ns/1ps
module xchg_bank_exchanger
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  input  logic         b1_drv,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  input  logic         b2_drv,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         ld_a_b1_n,
  input  logic         ld_a_b2_n,
  input  logic         ld_b1_a_n,
  input  logic         ld_b2_a_n,
  input  logic         rsel,
  input  logic         a_en_n,
  input  logic         b_en_n
);
  ctrl_t        ctrl_q;
  logic [W-1:0] path_q  [NUM_PATHS];
  logic         path_ld_n [NUM_PATHS];
  logic [W-1:0] seen    [NUM_PORTS];
  logic         ext_drv_v [NUM_PORTS];
  logic [W-1:0] ext_val_v [NUM_PORTS];
  logic         own_oe_v  [NUM_PORTS];
  logic [W-1:0] own_val_v [NUM_PORTS];

  // registered direction and select
  xchg_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rsel   (rsel),
    .a_en_n (a_en_n),
    .b_en_n (b_en_n),
    .ctrl_q (ctrl_q)
  );

  // outputs come from registered state only
  assign a_out  = ctrl_q.sel_b1 ? path_q[P_B1_A] : path_q[P_B2_A];
  assign a_oe   = ~ctrl_q.a_off;
  assign b1_out = path_q[P_A_B1];
  assign b2_out = path_q[P_A_B2];
  assign b1_oe  = ~ctrl_q.b_off;
  assign b2_oe  = ~ctrl_q.b_off;

  // per-port pin model
  assign ext_drv_v[PORT_A]  = a_drv;
  assign ext_drv_v[PORT_B1] = b1_drv;
  assign ext_drv_v[PORT_B2] = b2_drv;
  assign ext_val_v[PORT_A]  = a_in;
  assign ext_val_v[PORT_B1] = b1_in;
  assign ext_val_v[PORT_B2] = b2_in;
  assign own_oe_v[PORT_A]   = a_oe;
  assign own_oe_v[PORT_B1]  = b1_oe;
  assign own_oe_v[PORT_B2]  = b2_oe;
  assign own_val_v[PORT_A]  = a_out;
  assign own_val_v[PORT_B1] = b1_out;
  assign own_val_v[PORT_B2] = b2_out;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    xchg_keeper #(.W(W)) u_keep (
      .clk     (clk),
      .rst     (rst),
      .ext_drv (ext_drv_v[k]),
      .ext_val (ext_val_v[k]),
      .own_oe  (own_oe_v[k]),
      .own_val (own_val_v[k]),
      .seen    (seen[k])
    );
  end

  assign path_ld_n[P_A_B1] = ld_a_b1_n;
  assign path_ld_n[P_A_B2] = ld_a_b2_n;
  assign path_ld_n[P_B1_A] = ld_b1_a_n;
  assign path_ld_n[P_B2_A] = ld_b2_a_n;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [W-1:0] d_src;
    if (p == P_A_B1 || p == P_A_B2) begin : g_from_a
      assign d_src = seen[PORT_A];
    end else begin : g_from_b
      assign d_src = seen[p - 1];  // B1->A reads port B1, B2->A reads port B2
    end
    xchg_dreg #(.W(W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .ld_n (path_ld_n[p]),
      .d    (d_src),
      .q    (path_q[p])
    );
  end

  // R1: state right after a reset edge
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a_oe && !b1_oe && !b2_oe &&
                    a_out == '0 && b1_out == '0 && b2_out == '0));

  // R3: both outbound strobes on one edge store one word in both
  p_dual_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_a_b1_n) && !$past(ld_a_b2_n)) |-> (b1_out == b2_out));

  // R10: with no edge-time change of state inputs, outputs hold
  p_no_comb_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_b1_a_n) && $past(ld_b2_a_n) &&
     $past(rsel) == ctrl_q.sel_b1 && $past(ctrl_q.sel_b1) == ctrl_q.sel_b1) |-> $stable(a_out));
endmodule

// File: tb/sim_xchg_bank_exchanger.sv
`timescale 1ns/1ps
module sim_xchg_bank_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic a_drv = 1'b0, b1_drv = 1'b0, b2_drv = 1'b0;
  logic ld_a_b1_n = 1'b1, ld_a_b2_n = 1'b1, ld_b1_a_n = 1'b1, ld_b2_a_n = 1'b1;
  logic rsel = 1'b1, a_en_n = 1'b1, b_en_n = 1'b1;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  always #10 clk = ~clk;  // 50 MHz

  xchg_bank_exchanger #(.W(W)) u0 (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_drv(b1_drv), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_drv(b2_drv), .b2_out(b2_out), .b2_oe(b2_oe),
    .ld_a_b1_n(ld_a_b1_n), .ld_a_b2_n(ld_a_b2_n),
    .ld_b1_a_n(ld_b1_a_n), .ld_b2_a_n(ld_b2_a_n),
    .rsel(rsel), .a_en_n(a_en_n), .b_en_n(b_en_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [W-1:0] m_out1, m_out2, m_in1, m_in2, m_ka, m_k1, m_k2;
  logic m_sel = 1'b1, m_a_on = 1'b0, m_b_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [W-1:0] ra, r1, r2, aview;
    aview = m_sel ? m_in1 : m_in2;
    ra = a_drv  ? a_in  : (m_a_on ? aview  : m_ka);
    r1 = b1_drv ? b1_in : (m_b_on ? m_out1 : m_k1);
    r2 = b2_drv ? b2_in : (m_b_on ? m_out2 : m_k2);
    if (rst) begin
      m_out1 = '0; m_out2 = '0; m_in1 = '0; m_in2 = '0;
      m_ka = '0; m_k1 = '0; m_k2 = '0;
      m_sel = 1'b1; m_a_on = 1'b0; m_b_on = 1'b0;
    end else begin
      m_ka = ra; m_k1 = r1; m_k2 = r2;
      if (!ld_a_b1_n) m_out1 = ra;
      if (!ld_a_b2_n) m_out2 = ra;
      if (!ld_b1_a_n) m_in1 = r1;
      if (!ld_b2_a_n) m_in2 = r2;
      m_sel = rsel; m_a_on = !a_en_n; m_b_on = !b_en_n;
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] exp_a;
    exp_a = m_sel ? m_in1 : m_in2;
    chk(a_out === exp_a, "R6 a_out", 32'(a_out), 32'(exp_a));
    chk(a_oe === m_a_on, "R7 a_oe", 32'(a_oe), 32'(m_a_on));
    chk(b1_oe === m_b_on && b2_oe === m_b_on, "R8 b_oe", {b1_oe, b2_oe}, {m_b_on, m_b_on});
    chk(b1_out === m_out1, "R2 b1_out", 32'(b1_out), 32'(m_out1));
    chk(b2_out === m_out2, "R3 b2_out", 32'(b2_out), 32'(m_out2));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] snap_a, snap_b1;
    logic snap_oe;
    repeat (3) tick();
    // R1: reset state
    chk(a_oe == 0 && b1_oe == 0 && b2_oe == 0, "R1 oe after reset", {a_oe, b1_oe, b2_oe}, 0);
    chk(a_out == 0 && b1_out == 0 && b2_out == 0, "R1 data after reset", 32'(a_out | b1_out | b2_out), 0);
    rst = 0;

    // R2/R3: one host word into both bank registers on one edge
    a_drv = 1; a_in = 12'h5A3; ld_a_b1_n = 0; ld_a_b2_n = 0; b_en_n = 0;
    chk(b1_oe == 0, "R8 enable not yet applied", 32'(b1_oe), 0);
    tick();
    chk(b1_out == 12'h5A3 && b2_out == 12'h5A3, "R3 dual load", {b1_out, b2_out}, {12'h5A3, 12'h5A3});
    chk(b1_oe == 1 && b2_oe == 1, "R8 B driven one edge later", {b1_oe, b2_oe}, 2'b11);

    // R2 + R5: only B1 register loads
    a_in = 12'h0F1; ld_a_b2_n = 1;
    tick();
    chk(b1_out == 12'h0F1, "R2 single load", 32'(b1_out), 32'h0F1);
    chk(b2_out == 12'h5A3, "R5 B2 register held", 32'(b2_out), 32'h5A3);
    a_in = 12'hE2C; ld_a_b1_n = 1; ld_a_b2_n = 0;
    tick();
    chk(b1_out == 12'h0F1 && b2_out == 12'hE2C, "R3 B2-only load", {b1_out, b2_out}, {12'h0F1, 12'hE2C});
    ld_a_b2_n = 1; a_drv = 0;

    // R4/R6/R7: release B, load inbound from pins, alternate banks
    b_en_n = 1;
    tick();
    b1_drv = 1; b1_in = 12'h333; b2_drv = 1; b2_in = 12'h777;
    ld_b1_a_n = 0; ld_b2_a_n = 0; a_en_n = 0; rsel = 1;
    tick();
    chk(a_out == 12'h333, "R4 inbound B1 via select 1", 32'(a_out), 32'h333);
    chk(a_oe == 1, "R7 A driven one edge later", 32'(a_oe), 1);
    ld_b1_a_n = 1; ld_b2_a_n = 1; rsel = 0;
    tick();
    chk(a_out == 12'h777, "R6 select 0 shows B2 register", 32'(a_out), 32'h777);
    for (int i = 0; i < 4; i++) begin
      rsel = ~rsel;
      tick();
    end
    chk(a_out == 12'h777, "R6 alternation ends on B2", 32'(a_out), 32'h777);

    // R5: strobe high ignores new pin data
    b1_in = 12'hABC; rsel = 1;
    tick();
    chk(a_out == 12'h333, "R5 inbound hold", 32'(a_out), 32'h333);

    // R9: keeper holds last driven B1 level
    b1_in = 12'h456;
    tick();
    b1_drv = 0; b1_in = 12'hFFF;
    tick(); tick();
    ld_b1_a_n = 0;
    tick();
    chk(a_out == 12'h456, "R9 keeper level loaded", 32'(a_out), 32'h456);
    // R9: own drive seen on the input path
    ld_b1_a_n = 1; b_en_n = 0;
    tick();
    ld_b1_a_n = 0;
    tick();
    chk(a_out == 12'h0F1, "R9 own drive loaded", 32'(a_out), 32'h0F1);
    ld_b1_a_n = 1;

    // R10: mid-cycle input changes do not reach outputs
    snap_a = a_out; snap_b1 = b1_out; snap_oe = a_oe;
    rsel = 0; a_en_n = 1; a_drv = 1; a_in = 12'h999; ld_a_b1_n = 0;
    #5;
    chk(a_out == snap_a && b1_out == snap_b1 && a_oe == snap_oe, "R10 no comb path",
        {a_out, b1_out, a_oe}, {snap_a, snap_b1, snap_oe});
    tick();
    ld_a_b1_n = 1;

    // mixed traffic with occasional reset
    for (int i = 0; i < 400; i++) begin
      rst = ($urandom_range(0, 49) == 0);
      a_in = 12'($urandom); b1_in = 12'($urandom); b2_in = 12'($urandom);
      a_drv = 1'($urandom); b1_drv = 1'($urandom); b2_drv = 1'($urandom);
      ld_a_b1_n = 1'($urandom); ld_a_b2_n = 1'($urandom);
      ld_b1_a_n = 1'($urandom); ld_b2_a_n = 1'($urandom);
      rsel = 1'($urandom); a_en_n = 1'($urandom); b_en_n = 1'($urandom);
      tick();
    end
    finish_run();
  end
endmodule